// File: doc/BRIEF.md
# Dual External Interrupt Pin Conditioner

This block turns two asynchronous, active-low interrupt pins into request flags for a downstream interrupt controller. Each pin passes through a synchroniser and is then sampled once per machine cycle, which is marked by a single-clock strobe input. A per-pin mode bit selects the detection type. In level mode the request flag copies the inverted sample. In falling-edge mode a high sample followed by a low sample latches the flag, and the flag stays set until the controller acknowledges it.

Software sees one 8-bit control/flag byte. The low nibble holds the two mode bits and the two request flags. The high nibble is four bits of plain storage that other timer logic owns and this block only keeps. The interface has no streaming data path, so every pin is a plain control or status signal and none has back-pressure. A write is a single-cycle strobe with a data byte. A read is the byte, which is always present on the output.

Top module: `xirq_detect`

## Requirements
- R1: After reset the register byte reads 0x00 and both request outputs are 0.
- R2: A write stores data bits 7:4 as the upper nibble, bit 0 as the source 0 mode and bit 2 as the source 1 mode. The byte reads back as {upper nibble, flag1, mode1, flag0, mode0}, so flag 0 is bit 1 and flag 1 is bit 3.
- R3: With mode bit 0 (level), a clock with the strobe high loads the flag with the inverse of the synchronised pin. Without the strobe, the flag holds its value.
- R4: With mode bit 1 (edge), the flag is set when a strobed sample reads low and the previous strobed sample read high. A pin that stays low does not set the flag again.
- R5: A low pulse that starts and ends between two strobes is never seen, in either mode.
- R6: In edge mode, an acknowledge clears the flag on the next clock.
- R7: In level mode an acknowledge has no effect. While the pin stays low the flag stays set, and it drops only after a strobe samples the pin high.
- R8: In level mode, a software write to a flag bit has no effect.
- R9: In edge mode, a software write sets or clears the flag to the written bit.
- R10: In edge mode, a hardware edge in the same clock as an acknowledge or a clearing write leaves the flag set.
- R11: Output req[i] always equals flag bit i of the register byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_stb | input | 1 | One-clock machine-cycle sampling strobe |
| pin_n | input | 2 | Asynchronous active-low interrupt pins |
| ack | input | 2 | Per-source acknowledge pulse from the controller |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read view |
| req | output | 2 | Request flags to the controller |

## Verification
Slow pin falls that span several strobes are applied in both modes. Under them, level tracking must follow the pin, while edge detection must latch once and ignore a pin that stays low. Short glitches placed between strobes tell strobed sampling apart from detection on every clock. Acknowledges and software writes are applied in each mode, and a write or acknowledge is timed onto the strobe that carries an edge to check which action wins. A long random phase mixes all inputs against the reference model.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned SRC_N = 2;
  localparam int unsigned REG_W = 8;

  typedef struct packed {
    logic f1;
    logic r1;
    logic f0;
    logic r0;
  } aux_t;

  function automatic int unsigned mode_pos(input int unsigned i);
    return 2 * i;
  endfunction

  function automatic int unsigned flag_pos(input int unsigned i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '1;
        else if (s == 0) chain_q[s] <= d_in;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic ack,
  input  logic sw_we,
  input  logic sw_val,
  output logic pend
);
  logic smp_q;
  logic pend_q;
  logic edge_evt;

  assign edge_evt = stb & smp_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (stb) smp_q <= pin_s;
      if (!edge_mode) begin
        if (stb) pend_q <= ~pin_s;
      end else if (edge_evt) begin
        pend_q <= 1'b1;
      end else if (ack) begin
        pend_q <= 1'b0;
      end else if (sw_we) begin
        pend_q <= sw_val;
      end
    end
  end

  assign pend = pend_q;

  p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && stb) |=> (pend == !$past(pin_s)));
  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !stb) |=> $stable(pend));
  p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && stb && smp_q && !pin_s) |=> pend);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !(stb && smp_q && !pin_s)) |=> !pend);
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_evt && (ack || sw_we)) |=> pend);
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_stb,
  input  logic [SRC_N-1:0] pin_n,
  input  logic [SRC_N-1:0] ack,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [SRC_N-1:0] req
);
  localparam int unsigned LOW_W = 2 * SRC_N;

  aux_t             aux_q;
  logic [SRC_N-1:0] mode_q;
  logic [SRC_N-1:0] pin_s;
  logic [SRC_N-1:0] pend;
  logic [LOW_W-1:0] low_view;

  xirq_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_n),
    .d_out (pin_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux_q  <= '0;
      mode_q <= '0;
    end else if (reg_we) begin
      aux_q <= aux_t'(reg_wdata[REG_W-1:LOW_W]);
      for (int i = 0; i < SRC_N; i++) mode_q[i] <= reg_wdata[mode_pos(i)];
    end
  end

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
      xirq_chan u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (mc_stb),
        .pin_s     (pin_s[g]),
        .edge_mode (mode_q[g]),
        .ack       (ack[g]),
        .sw_we     (reg_we),
        .sw_val    (reg_wdata[flag_pos(g)]),
        .pend      (pend[g])
      );
      assign low_view[mode_pos(g)] = mode_q[g];
      assign low_view[flag_pos(g)] = pend[g];
    end
  endgenerate

  assign reg_rdata = {aux_q, low_view};
  assign req       = pend;

  p_aux_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_rdata[REG_W-1:LOW_W] == $past(reg_wdata[REG_W-1:LOW_W])));
  p_mode_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_rdata[0] == $past(reg_wdata[0]) && reg_rdata[2] == $past(reg_wdata[2])));
  p_level_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[0] && ack[0] && !mc_stb) |=> (req[0] == $past(req[0])));
endmodule

// File: tb/sim_xirq_detect.sv
module sim_xirq_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_stb;
  logic [1:0] pin_n = 2'b11;
  logic [1:0] ack = 2'b00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] req;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(negedge clk) stb_cnt <= (stb_cnt + 1) % 8;
  assign mc_stb = (stb_cnt == 0);

  xirq_detect u0 (
    .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .pin_n(pin_n), .ack(ack),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req)
  );

  // behavioural reference model
  bit [1:0] m_d1, m_d2, m_smp, m_pend, m_mode;
  bit [3:0] m_aux;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 = 2'b11; m_d2 = 2'b11; m_smp = 2'b11;
      m_pend = 0; m_mode = 0; m_aux = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (m_mode[i] == 0) begin
          if (mc_stb) m_pend[i] = !m_d2[i];
        end else if (mc_stb && m_smp[i] && !m_d2[i]) m_pend[i] = 1;
        else if (ack[i]) m_pend[i] = 0;
        else if (reg_we) m_pend[i] = reg_wdata[2*i+1];
      end
      if (mc_stb) m_smp = m_d2;
      m_d2 = m_d1;
      m_d1 = pin_n;
      if (reg_we) begin
        m_aux = reg_wdata[7:4];
        m_mode = {reg_wdata[2], reg_wdata[0]};
      end
    end
  end

  function automatic bit [7:0] m_view();
    return {m_aux, m_pend[1], m_mode[1], m_pend[0], m_mode[0]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 view", reg_rdata, m_view());
      for (int i = 0; i < 2; i++)
        chk(m_mode[i] ? "R4 flag" : "R3 flag", req[i], m_pend[i]);
      chk("R11 req", req, {reg_rdata[3], reg_rdata[1]});
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic to_stb();
    do tick(1); while (!mc_stb);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1; reg_wdata = v; tick(1); reg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1; tick(1);
    chk("R1 reset byte", reg_rdata, 8'h00);
    chk("R1 reset req", req, 0);

    wr(8'hA5); tick(1);
    chk("R2 readback", reg_rdata, 8'hA5);

    // edge on source 0
    to_stb(); pin_n[0] = 0; tick(20);
    chk("R4 edge set", req[0], 1);
    ack = 2'b01; tick(1); ack = 0;
    chk("R6 ack clears", req[0], 0);
    tick(20);
    chk("R4 steady low no reset", req[0], 0);

    // software write in edge mode
    wr(8'hAD); chk("R9 sw set", req[1], 1);
    wr(8'hA5); chk("R9 sw clear", req[1], 0);

    // glitch between strobes
    to_stb(); pin_n[1] = 0; tick(1); pin_n[1] = 1; tick(20);
    chk("R5 glitch ignored", req[1], 0);

    // edge coincides with ack and clearing write
    to_stb(); pin_n[1] = 0;
    to_stb(); reg_we = 1; reg_wdata = 8'hA5; ack = 2'b10;
    tick(1); reg_we = 0; ack = 0;
    chk("R10 edge wins", req[1], 1);
    pin_n[1] = 1; wr(8'hA5);

    // level mode: pin0 still low
    wr(8'hA0); tick(10);
    chk("R3 level set", req[0], 1);
    ack = 2'b01; tick(1); ack = 0; tick(10);
    chk("R7 ack ignored", req[0], 1);
    wr(8'hA0); tick(1);
    chk("R8 write clear ignored", req[0], 1);
    pin_n[0] = 1; tick(12);
    chk("R3 level drop", req[0], 0);
    wr(8'hA2); tick(1);
    chk("R8 write set ignored", req[0], 0);
    to_stb(); pin_n[0] = 0; tick(1); pin_n[0] = 1; tick(20);
    chk("R5 level glitch ignored", req[0], 0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 9) == 0) pin_n = 2'($urandom);
      ack = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      reg_we = ($urandom_range(0, 15) == 0);
      reg_wdata = 8'($urandom);
      tick(1);
    end
    reg_we = 0; ack = 0;
    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule